// File: doc/BRIEF.md
# Smart card T=0 character transmitter

This block sends 8-bit characters over the single open-drain I/O line of a contact smart card, using the character-level error detection and retransmission of the T=0 protocol. Software writes a character into a one-entry transmit data register. When the transmitter is free, it copies that character into its frame shifter and marks the register empty. It then puts a low start bit on the line, followed by eight data bits (least significant first) and an even parity bit. Each bit lasts one elementary time unit (ETU). The length of an ETU is set by a stream of bit-rate ticks from outside: `SUB_PER_ETU` ticks make one ETU.

After the parity bit the line is released for an error-signal slot. The transmitter samples the line in the middle of that slot. If the card pulls the line low there, the transmitter raises an error flag and does not report completion. Two ETUs after the slot it sends the same character again. A retry counter limits how many times a character is resent. When the limit is used up and the card signals an error once more, the character is dropped and a retry-overrun flag stops all further transmission until software clears it.

A character that passes without an error signal counts as delivered. If no other character is waiting, the transmit-end flag is raised. Each of the error and transmit-end flags has an interrupt enable, and each interrupt output is the flag gated by its enable.

Top module: `sc_t0_tx`

## Requirements
- R1: A frame starts with a start bit at 0, then D0 to D7 least significant first, then a parity bit chosen so that D0..D7 plus the parity bit hold an even number of ones. Each bit lasts `SUB_PER_ETU` ticks. The line value is the inverse of `io_drive_low`.
- R2: `io_drive_low` is 0 whenever the transmitter is idle or in the error-signal slot that follows the parity bit.
- R3: If `io_in` is 0 at the sample point of the slot, `err_flag` is set to 1. The sample point is tick 10*SUB_PER_ETU + SUB_PER_ETU/2 after the start edge. `err_irq` equals `err_flag` AND `err_ie`.
- R4: A one-cycle pulse on `err_clr` clears `err_flag` to 0. A new error event in the same cycle takes priority and leaves the flag at 1.
- R5: After an error signal, `tx_end` stays at 0 and the same character is sent again. The start edge of the resent frame comes exactly 13 ETUs after the start edge of the frame that was rejected.
- R6: After a slot with no error signal, `err_flag` is left unchanged. If the transmit data register is empty at that point, `tx_end` is set to 1. `tend_irq` equals `tx_end` AND `tend_ie`.
- R7: A write (`wr_en`) loads `wr_data`, clears `tdr_empty` and clears `tx_end`. At the start edge of a new character, the register contents move to the shifter and `tdr_empty` is set to 1.
- R8: If another character is waiting when a frame completes cleanly, `tx_end` stays at 0 and the waiting character is sent next.
- R9: At most `max_retries` resends follow the first frame. The next error after that sets `retry_ovf`, drops the character and leaves `tx_end` at 0. No frame starts while `retry_ovf` is 1. A pulse on `ovf_clr` clears it, and a waiting character is then sent.
- R10: After reset, `tdr_empty` and `tx_end` are 1, `err_flag` and `retry_ovf` are 0, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | Bit-rate tick, SUB_PER_ETU per ETU, one cycle wide |
| wr_en | input | 1 | Write strobe for the transmit data register |
| wr_data | input | 8 | Character to transmit |
| err_clr | input | 1 | Clear pulse for err_flag |
| ovf_clr | input | 1 | Clear pulse for retry_ovf |
| err_ie | input | 1 | Error interrupt enable |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| max_retries | input | RETRY_W | Maximum number of resends per character |
| io_in | input | 1 | Sampled level of the I/O line |
| io_drive_low | output | 1 | 1 pulls the line low; 0 releases it to the pull-up |
| tdr_empty | output | 1 | Transmit data register empty |
| tx_end | output | 1 | Last character delivered with no error signal |
| err_flag | output | 1 | Error signal seen after a character |
| retry_ovf | output | 1 | Retry limit exceeded; transmission stopped |
| err_irq | output | 1 | Error interrupt request |
| tend_irq | output | 1 | Transmit-end interrupt request |

## Verification
On every cycle, the assertions check that the line is released while idle and during the slot, and that an error event always sets the error flag and leaves the transmit-end flag unchanged. They also check that the retry count never goes above its limit, that no frame starts while the overrun flag is set, and that a frame start empties the data register. Other behaviours can only be shown by the bench scenarios, which watch the line as a card would. These are the bit order and parity on the line, the exact 13-ETU spacing of a resent frame, and the identity of the resent character. The same holds for the transmit-end flag after a clean completion with and without a character waiting, the clear pulses, and the release from overrun.

// File: rtl/sc_t0_pkg.sv
`timescale 1ns/1ps
package sc_t0_pkg;

    // Start bit, eight data bits, parity bit.
    localparam int FRAME_BITS = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SLOT = 2'd2,
        ST_WAIT = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic tdr_empty;
        logic tx_end;
        logic err;
        logic ovf;
    } tx_flags_t;

    // Even parity over the data bits.
    function automatic logic even_parity(input logic [7:0] d);
        return ^d;
    endfunction

    // Bit 0 leaves the shifter first: start, D0..D7, parity.
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
        return {even_parity(d), d, 1'b0};
    endfunction

endpackage

// File: rtl/sc_t0_etu_timer.sv
`timescale 1ns/1ps
module sc_t0_etu_timer #(
    parameter int SUB_PER_ETU = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic etu_end,
    output logic mid
);
    localparam int SUB_W = (SUB_PER_ETU > 2) ? $clog2(SUB_PER_ETU) : 1;
    localparam int HALF  = SUB_PER_ETU / 2;

    logic [SUB_W-1:0] sub_q;

    // The tick that closes the current ETU, and the tick at its centre.
    assign etu_end = tick && (sub_q == SUB_W'(SUB_PER_ETU - 1));
    assign mid     = tick && (sub_q == SUB_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
        end else if (restart) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= etu_end ? '0 : sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_t0_shifter.sv
`timescale 1ns/1ps
module sc_t0_shifter
    import sc_t0_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_char,
    input  logic       shift,
    input  logic       release_line,
    output logic       drive_low
);
    logic [FRAME_BITS-1:0] frame_q;
    logic [FRAME_BITS-1:0] new_frame;

    assign new_frame = build_frame(load_char);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= '1;
            drive_low <= 1'b0;
        end else if (load) begin
            frame_q   <= new_frame;
            drive_low <= ~new_frame[0];
        end else if (shift) begin
            frame_q   <= {1'b1, frame_q[FRAME_BITS-1:1]};
            drive_low <= ~frame_q[1];
        end else if (release_line) begin
            drive_low <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_t0_ctrl.sv
`timescale 1ns/1ps
module sc_t0_ctrl
    import sc_t0_pkg::*;
#(
    parameter int RETRY_W     = 3,
    parameter int GUARD_ETU   = 1,
    parameter int ERR_GAP_ETU = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               etu_end,
    input  logic               mid,
    input  logic               line_in,
    input  logic               pending,
    input  logic               stopped,
    input  logic [RETRY_W-1:0] max_retries,
    output tx_state_e          st,
    output logic [RETRY_W-1:0] retry_cnt,
    output logic               start_new,
    output logic               load,
    output logic               restart,
    output logic               shift,
    output logic               release_line,
    output logic               err_evt,
    output logic               ok_evt,
    output logic               ovf_evt
);
    localparam int BIT_W    = $clog2(FRAME_BITS);
    localparam int WAIT_MAX = (GUARD_ETU > ERR_GAP_ETU) ? GUARD_ETU : ERR_GAP_ETU;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

    logic [BIT_W-1:0]  bit_idx;
    logic [WAIT_W-1:0] wcnt;
    logic              nack_q;
    logic              give_up_q;
    logic              at_limit;

    assign at_limit = (retry_cnt == max_retries);

    always_comb begin
        start_new    = 1'b0;
        load         = 1'b0;
        restart      = 1'b0;
        shift        = 1'b0;
        release_line = 1'b0;
        err_evt      = 1'b0;
        ok_evt       = 1'b0;
        ovf_evt      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (tick && pending && !stopped) begin
                    start_new = 1'b1;
                    load      = 1'b1;
                    restart   = 1'b1;
                end
            end
            ST_DATA: begin
                if (etu_end) begin
                    if (bit_idx == BIT_W'(FRAME_BITS - 1)) release_line = 1'b1;
                    else                                   shift        = 1'b1;
                end
            end
            ST_SLOT: begin
                if (mid) begin
                    if (!line_in) begin
                        err_evt = 1'b1;
                        ovf_evt = at_limit;
                    end else begin
                        ok_evt = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                // Resend starts on the tick closing the last gap ETU.
                if (etu_end && wcnt == WAIT_W'(1) && nack_q && !give_up_q) begin
                    load    = 1'b1;
                    restart = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bit_idx   <= '0;
            wcnt      <= '0;
            nack_q    <= 1'b0;
            give_up_q <= 1'b0;
            retry_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start_new) begin
                        st        <= ST_DATA;
                        bit_idx   <= '0;
                        retry_cnt <= '0;
                    end
                end
                ST_DATA: begin
                    if (etu_end) begin
                        if (bit_idx == BIT_W'(FRAME_BITS - 1)) st <= ST_SLOT;
                        else bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (mid) begin
                        nack_q    <= !line_in;
                        give_up_q <= !line_in && at_limit;
                    end
                    if (etu_end) begin
                        st   <= ST_WAIT;
                        wcnt <= nack_q ? WAIT_W'(ERR_GAP_ETU) : WAIT_W'(GUARD_ETU);
                    end
                end
                ST_WAIT: begin
                    if (etu_end) begin
                        if (wcnt == WAIT_W'(1)) begin
                            if (load) begin
                                st        <= ST_DATA;
                                bit_idx   <= '0;
                                retry_cnt <= retry_cnt + 1'b1;
                            end else begin
                                st        <= ST_IDLE;
                                retry_cnt <= '0;
                            end
                        end else begin
                            wcnt <= wcnt - 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_t0_status.sv
`timescale 1ns/1ps
module sc_t0_status
    import sc_t0_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       err_clr,
    input  logic       ovf_clr,
    input  logic       start_new,
    input  logic       err_evt,
    input  logic       ok_evt,
    input  logic       ovf_evt,
    output logic [7:0] tdr_q,
    output tx_flags_t  flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tdr_q           <= '0;
            flags.tdr_empty <= 1'b1;
            flags.tx_end    <= 1'b1;
            flags.err       <= 1'b0;
            flags.ovf       <= 1'b0;
        end else begin
            if (wr_en) tdr_q <= wr_data;

            // A write in the cycle of a start is a new pending character.
            if (wr_en)          flags.tdr_empty <= 1'b0;
            else if (start_new) flags.tdr_empty <= 1'b1;

            if (wr_en)                           flags.tx_end <= 1'b0;
            else if (ok_evt && flags.tdr_empty)  flags.tx_end <= 1'b1;

            if (err_evt)      flags.err <= 1'b1;
            else if (err_clr) flags.err <= 1'b0;

            if (ovf_evt)      flags.ovf <= 1'b1;
            else if (ovf_clr) flags.ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_t0_tx.sv
`timescale 1ns/1ps
module sc_t0_tx
    import sc_t0_pkg::*;
#(
    parameter int SUB_PER_ETU = 4,
    parameter int RETRY_W     = 3,
    parameter int GUARD_ETU   = 1,
    parameter int ERR_GAP_ETU = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               etu_tick,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               err_clr,
    input  logic               ovf_clr,
    input  logic               err_ie,
    input  logic               tend_ie,
    input  logic [RETRY_W-1:0] max_retries,
    input  logic               io_in,
    output logic               io_drive_low,
    output logic               tdr_empty,
    output logic               tx_end,
    output logic               err_flag,
    output logic               retry_ovf,
    output logic               err_irq,
    output logic               tend_irq
);
    tx_state_e          st;
    tx_flags_t          flags;
    logic [RETRY_W-1:0] retry_cnt;
    logic [7:0]         tdr_q;
    logic [7:0]         cur_char;
    logic [7:0]         load_char;
    logic etu_end, mid;
    logic start_new, load, restart, shift, release_line;
    logic err_evt, ok_evt, ovf_evt;

    sc_t0_etu_timer #(.SUB_PER_ETU(SUB_PER_ETU)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (etu_tick),
        .restart (restart),
        .etu_end (etu_end),
        .mid     (mid)
    );

    sc_t0_ctrl #(
        .RETRY_W     (RETRY_W),
        .GUARD_ETU   (GUARD_ETU),
        .ERR_GAP_ETU (ERR_GAP_ETU)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick         (etu_tick),
        .etu_end      (etu_end),
        .mid          (mid),
        .line_in      (io_in),
        .pending      (!flags.tdr_empty),
        .stopped      (flags.ovf),
        .max_retries  (max_retries),
        .st           (st),
        .retry_cnt    (retry_cnt),
        .start_new    (start_new),
        .load         (load),
        .restart      (restart),
        .shift        (shift),
        .release_line (release_line),
        .err_evt      (err_evt),
        .ok_evt       (ok_evt),
        .ovf_evt      (ovf_evt)
    );

    sc_t0_status u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .err_clr   (err_clr),
        .ovf_clr   (ovf_clr),
        .start_new (start_new),
        .err_evt   (err_evt),
        .ok_evt    (ok_evt),
        .ovf_evt   (ovf_evt),
        .tdr_q     (tdr_q),
        .flags     (flags)
    );

    // Copy kept for resends, since the data register may be rewritten.
    always_ff @(posedge clk) begin
        if (rst)            cur_char <= '0;
        else if (start_new) cur_char <= tdr_q;
    end

    assign load_char = start_new ? tdr_q : cur_char;

    sc_t0_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .load_char    (load_char),
        .shift        (shift),
        .release_line (release_line),
        .drive_low    (io_drive_low)
    );

    assign tdr_empty = flags.tdr_empty;
    assign tx_end    = flags.tx_end;
    assign err_flag  = flags.err;
    assign retry_ovf = flags.ovf;
    assign err_irq   = flags.err & err_ie;
    assign tend_irq  = flags.tx_end & tend_ie;
endmodule

// File: rtl/sc_t0_tx_chk.sv
`timescale 1ns/1ps
module sc_t0_tx_chk
    import sc_t0_pkg::*;
#(
    parameter int RETRY_W = 3
) (
    input logic               clk,
    input logic               rst,
    input tx_state_e          st,
    input logic               io_drive_low,
    input logic               wr_en,
    input logic               start_new,
    input logic               err_evt,
    input logic               tdr_empty,
    input logic               tx_end,
    input logic               err_flag,
    input logic               retry_ovf,
    input logic [RETRY_W-1:0] retry_cnt,
    input logic [RETRY_W-1:0] max_retries
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !io_drive_low); // R2

    AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOT) |-> !io_drive_low); // R2

    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> err_flag); // R3

    AST_ERR_HOLDS_TEND: assert property (@(posedge clk) disable iff (rst)
        (err_evt && !wr_en) |=> $stable(tx_end)); // R5

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        retry_cnt <= max_retries); // R9

    AST_NO_START_STOPPED: assert property (@(posedge clk) disable iff (rst)
        retry_ovf |-> !start_new); // R9

    AST_START_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (start_new && !wr_en) |=> tdr_empty); // R7
endmodule

bind sc_t0_tx sc_t0_tx_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .st           (st),
    .io_drive_low (io_drive_low),
    .wr_en        (wr_en),
    .start_new    (start_new),
    .err_evt      (err_evt),
    .tdr_empty    (tdr_empty),
    .tx_end       (tx_end),
    .err_flag     (err_flag),
    .retry_ovf    (retry_ovf),
    .retry_cnt    (retry_cnt),
    .max_retries  (max_retries)
);

// File: tb/tb_sc_t0_tx.sv
`timescale 1ns/1ps
module tb_sc_t0_tx;
    localparam int SUB     = 4;
    localparam int HALF    = SUB / 2;
    localparam int RETRY_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic etu_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic err_clr = 1'b0, ovf_clr = 1'b0;
    logic err_ie = 1'b0, tend_ie = 1'b0;
    logic [RETRY_W-1:0] max_retries = 3'd4;
    logic card_low = 1'b0;
    logic io_in;
    logic io_drive_low, tdr_empty, tx_end, err_flag, retry_ovf, err_irq, tend_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int div    = 0;

    always #4 clk = ~clk;

    // One tick every four clocks.
    always @(negedge clk) begin
        etu_tick <= (div == 3);
        div      <= (div + 1) % 4;
    end

    assign io_in = !io_drive_low && !card_low;

    sc_t0_tx #(.SUB_PER_ETU(SUB), .RETRY_W(RETRY_W)) dut (
        .clk(clk), .rst(rst), .etu_tick(etu_tick), .wr_en(wr_en), .wr_data(wr_data),
        .err_clr(err_clr), .ovf_clr(ovf_clr), .err_ie(err_ie), .tend_ie(tend_ie),
        .max_retries(max_retries), .io_in(io_in), .io_drive_low(io_drive_low),
        .tdr_empty(tdr_empty), .tx_end(tx_end), .err_flag(err_flag),
        .retry_ovf(retry_ovf), .err_irq(err_irq), .tend_irq(tend_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!etu_tick);
        #1;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic put_char(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_err_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic pulse_ovf_clr();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    // Waits for a start edge (counting ticks), then decodes the frame as a
    // card would and answers in the slot. Returns at the end of the slot.
    task automatic recv_frame(input bit nack, output logic [9:0] bits,
                              output bit got, output int gap);
        gap = 0; got = 1'b0; bits = '0;
        while (!io_drive_low && gap < 40 * SUB) begin
            wait_tick();
            gap++;
        end
        if (!io_drive_low) return;
        got = 1'b1;
        wait_ticks(HALF);
        bits[0] = !io_drive_low;
        for (int k = 1; k < 10; k++) begin
            wait_ticks(SUB);
            bits[k] = !io_drive_low;
        end
        wait_ticks(HALF);
        card_low = nack;
        wait_ticks(HALF);
        chk(!io_drive_low, "R2", "line released in slot", io_drive_low, 0);
        wait_ticks(HALF);
        card_low = 1'b0;
    endtask

    task automatic chk_frame(input logic [9:0] bits, input logic [7:0] d,
                             input bit got, input string req);
        logic [9:0] exp;
        exp = {^d, d, 1'b0};
        chk(got, req, "frame seen", got, 1);
        chk(bits == exp, req, "frame bits", bits, exp);
    endtask

    task automatic expect_quiet(input int n, output bit quiet);
        quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            wait_tick();
            if (io_drive_low) quiet = 1'b0;
        end
    endtask

    task automatic test_reset();
        chk(tdr_empty == 1'b1, "R10", "tdr_empty", tdr_empty, 1);
        chk(tx_end == 1'b1, "R10", "tx_end", tx_end, 1);
        chk(err_flag == 1'b0, "R10", "err_flag", err_flag, 0);
        chk(retry_ovf == 1'b0, "R10", "retry_ovf", retry_ovf, 0);
        chk(io_drive_low == 1'b0, "R10", "line", io_drive_low, 0);
    endtask

    task automatic test_single();
        logic [9:0] b; bit got; int gap;
        tend_ie = 1'b1; err_ie = 1'b1;
        put_char(8'hA5);
        chk(tdr_empty == 1'b0, "R7", "tdr_empty after write", tdr_empty, 0);
        chk(tx_end == 1'b0, "R7", "tx_end after write", tx_end, 0);
        recv_frame(1'b0, b, got, gap);
        chk_frame(b, 8'hA5, got, "R1");
        chk(tdr_empty == 1'b1, "R7", "tdr_empty after start", tdr_empty, 1);
        chk(tx_end == 1'b1, "R6", "tx_end after clean frame", tx_end, 1);
        chk(tend_irq == 1'b1, "R6", "tend_irq", tend_irq, 1);
        chk(err_flag == 1'b0, "R6", "err_flag stays 0", err_flag, 0);
        chk(err_irq == 1'b0, "R3", "err_irq idle", err_irq, 0);
        tend_ie = 1'b0;
        #1;
        chk(tend_irq == 1'b0, "R6", "tend_irq masked", tend_irq, 0);
    endtask

    task automatic test_retry();
        logic [9:0] b; bit got; int gap;
        max_retries = 3'd4;
        put_char(8'h3C);
        recv_frame(1'b1, b, got, gap);
        chk_frame(b, 8'h3C, got, "R1");
        chk(err_flag == 1'b1, "R3", "err_flag after nack", err_flag, 1);
        chk(err_irq == 1'b1, "R3", "err_irq", err_irq, 1);
        chk(tx_end == 1'b0, "R5", "tx_end held", tx_end, 0);
        recv_frame(1'b0, b, got, gap);
        chk(gap == 2 * SUB, "R5", "resend gap ticks", gap, 2 * SUB);
        chk_frame(b, 8'h3C, got, "R5");
        chk(tx_end == 1'b1, "R6", "tx_end after resend ok", tx_end, 1);
        chk(err_flag == 1'b1, "R4", "err_flag kept until clear", err_flag, 1);
        pulse_err_clr();
        chk(err_flag == 1'b0, "R4", "err_flag cleared", err_flag, 0);
        chk(err_irq == 1'b0, "R4", "err_irq after clear", err_irq, 0);
    endtask

    task automatic test_b2b();
        logic [9:0] b; bit got; int gap;
        put_char(8'h01);
        gap = 0;
        while (!io_drive_low && gap < 40 * SUB) begin
            wait_tick();
            gap++;
        end
        chk(tdr_empty == 1'b1, "R7", "tdr_empty at start", tdr_empty, 1);
        put_char(8'hFE);
        recv_frame(1'b0, b, got, gap);
        chk_frame(b, 8'h01, got, "R8");
        chk(tx_end == 1'b0, "R8", "tx_end with char waiting", tx_end, 0);
        chk(tdr_empty == 1'b0, "R8", "second char pending", tdr_empty, 0);
        recv_frame(1'b0, b, got, gap);
        chk_frame(b, 8'hFE, got, "R8");
        chk(tx_end == 1'b1, "R8", "tx_end after last", tx_end, 1);
        chk(err_flag == 1'b0, "R6", "err_flag untouched", err_flag, 0);
    endtask

    task automatic test_limit();
        logic [9:0] b; bit got; int gap; bit quiet;
        max_retries = 3'd2;
        put_char(8'h5A);
        for (int i = 0; i < 3; i++) begin
            recv_frame(1'b1, b, got, gap);
            chk_frame(b, 8'h5A, got, "R9");
            if (i > 0) chk(gap == 2 * SUB, "R5", "resend gap ticks", gap, 2 * SUB);
        end
        expect_quiet(20 * SUB, quiet);
        chk(quiet, "R9", "no frame after limit", quiet, 1);
        chk(retry_ovf == 1'b1, "R9", "retry_ovf", retry_ovf, 1);
        chk(tx_end == 1'b0, "R9", "tx_end after give-up", tx_end, 0);
        put_char(8'hC3);
        expect_quiet(20 * SUB, quiet);
        chk(quiet, "R9", "no start while stopped", quiet, 1);
        pulse_ovf_clr();
        chk(retry_ovf == 1'b0, "R9", "retry_ovf cleared", retry_ovf, 0);
        recv_frame(1'b0, b, got, gap);
        chk_frame(b, 8'hC3, got, "R9");
        chk(tx_end == 1'b1, "R9", "tx_end after restart", tx_end, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_single();
        test_retry();
        test_b2b();
        test_limit();
        finish_run();
    end

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule